// File: doc/BRIEF.md
# Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A small global register keeps the outcomes of the most recent resolved branches. A table of saturating counters is arranged in rows, and a few low-order bits of the branch address pick the row. Each row holds one counter for every possible history pattern. The current history picks one counter in the row, and the top bit of that counter is the guess. No address tag is stored, so branches whose low address bits match share the same row.

Fetch drives a branch address on the lookup side. In the same cycle it gets back a taken guess and the history value that was used to make it. When the branch resolves, the pipeline returns the address, the history it saved at lookup and the real outcome. The block then trains the counter that made the guess and shifts the outcome into the history. If the history width is set to zero, the block becomes a plain counter table indexed by address.

Top module: `bp_correlating_predictor`

## Requirements
- R1: After reset every counter holds the weak not-taken value 2^(n-1)-1 and the history is all zeros, so every lookup returns `predTaken`=0 and `predHist`=0.
- R2: `predTaken` is combinational and equals the most significant bit of the counter chosen by the row in `lookPc` and the current history. It is 1 when the counter is at least 2^(n-1).
- R3: A valid update with `updTaken`=1 adds one to the chosen counter. A counter already at 2^n-1 stays there.
- R4: A valid update with `updTaken`=0 subtracts one from the chosen counter. A counter already at 0 stays there.
- R5: Each valid update shifts the outcome into bit 0 of the history, and the older bits move up by one place. `predHist` always shows the history as it stands.
- R6: An update trains only the counter whose row comes from `updPc` and whose column equals `updHist`. Every other counter, including the others in the same row, keeps its value.
- R7: The row index is `PC[PC_LSB +: ROW_BITS]` (bits 5:2 by default). The other address bits are ignored, so two addresses that differ only there get the same guess.
- R8: If a lookup and an update meet in one cycle, the lookup outputs show the state from before that update.
- R9: While `updValid`=0, no counter and no history bit changes, whatever the other update inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| lookPc | input | PC_WIDTH | Address of the branch being predicted |
| predTaken | output | 1 | Guess: 1 means taken |
| predHist | output | max(HIST_BITS,1) | History used for this guess; hold it until the branch resolves |
| updValid | input | 1 | Resolved-branch strobe |
| updPc | input | PC_WIDTH | Address of the resolved branch |
| updHist | input | max(HIST_BITS,1) | History saved from `predHist` at lookup time |
| updTaken | input | 1 | Actual outcome: 1 means taken |

## Verification
The assertions check several properties on every cycle. A counter never wraps past either limit, and a counter that is not enabled holds its value. At most one counter is enabled per update. The history shifts by exactly one place on each update, with the new outcome at bit 0, and stays stable when there is no update. Other behaviours only the bench scenarios can show, because they need values observed at the ports across many cycles. These are the weak not-taken reset value, selection of the counter by history inside a row, aliasing between addresses that share a row, and the pre-update read when a lookup and an update meet. The bench also runs a behavioural model on a random stream of lookups and updates and compares the outputs with it on every cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Strobes from the update control to the predictor datapath
  typedef struct packed {
    logic trainEn;   // modify exactly one counter this cycle
    logic countUp;   // direction of the counter step
    logic shiftEn;   // shift a new outcome into the global history
    logic shiftBit;  // outcome to shift in
  } bpStrobes_t;

endpackage

// File: rtl/bp_counter_cell.sv
module bp_counter_cell #(
  parameter int CTR_BITS = 2,
  parameter logic [CTR_BITS-1:0] RESET_VAL = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                en,
  input  logic                countUp,
  output logic [CTR_BITS-1:0] value
);

  localparam logic [CTR_BITS-1:0] CTR_MAX = {CTR_BITS{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      value <= RESET_VAL;
    end else if (en) begin
      if (countUp && (value != CTR_MAX)) begin
        value <= value + 1'b1;
      end else if (!countUp && (value != '0)) begin
        value <= value - 1'b1;
      end
    end
  end

  // R3
  ceiling_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en && countUp && value == CTR_MAX) |=> (value == CTR_MAX));

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en && countUp && value != CTR_MAX) |=> (value == $past(value) + 1'b1));

  // R4
  floor_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en && !countUp && value == '0) |=> (value == '0));

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en && !countUp && value != '0) |=> (value == $past(value) - 1'b1));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> $stable(value));

endmodule

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
#(
  parameter int HIST_BITS = 2
) (
  input  logic       updValid,
  input  logic       updTaken,
  output bpStrobes_t strobes
);

  localparam bit HAS_HIST = (HIST_BITS > 0);

  always_comb begin
    strobes          = '0;
    strobes.trainEn  = updValid;
    strobes.countUp  = updTaken;
    strobes.shiftEn  = updValid && HAS_HIST;
    strobes.shiftBit = updTaken;
  end

endmodule

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
#(
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2,
  parameter int ROW_BITS  = 4,
  parameter int PC_WIDTH  = 32,
  parameter int PC_LSB    = 2,
  parameter int HIST_W    = (HIST_BITS > 0) ? HIST_BITS : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  bpStrobes_t          strobes,
  input  logic [PC_WIDTH-1:0] lookPc,
  input  logic [PC_WIDTH-1:0] updPc,
  input  logic [HIST_W-1:0]   updHist,
  output logic                predTaken,
  output logic [HIST_W-1:0]   predHist
);

  localparam int IDX_BITS = ROW_BITS + HIST_BITS;
  localparam int ENTRIES  = 1 << IDX_BITS;
  localparam logic [CTR_BITS-1:0] CTR_INIT = CTR_BITS'((1 << (CTR_BITS - 1)) - 1);

  logic [ROW_BITS-1:0] lookRow;
  logic [ROW_BITS-1:0] updRow;
  logic [IDX_BITS-1:0] lookIdx;
  logic [IDX_BITS-1:0] updIdx;
  logic [HIST_W-1:0]   histQ;
  logic [ENTRIES-1:0]  cellEn;
  logic [CTR_BITS-1:0] ctrVal [ENTRIES];
  logic                unusedBits;

  assign lookRow = lookPc[PC_LSB +: ROW_BITS];
  assign updRow  = updPc[PC_LSB +: ROW_BITS];

  // Bits outside the row field carry no information for this table
  assign unusedBits = ^{lookPc, updPc, updHist, strobes.shiftEn, strobes.shiftBit};

  generate
    if (HIST_BITS > 0) begin : g_hist
      assign lookIdx = {lookRow, histQ};
      assign updIdx  = {updRow, updHist};

      if (HIST_BITS > 1) begin : g_wide
        always_ff @(posedge clk) begin
          if (!rstN)                histQ <= '0;
          else if (strobes.shiftEn) histQ <= {histQ[HIST_BITS-2:0], strobes.shiftBit};
        end

        // R5
        hist_age_chk: assert property (@(posedge clk) disable iff (!rstN)
          strobes.shiftEn |=> (histQ[HIST_BITS-1:1] == $past(histQ[HIST_BITS-2:0])));
      end else begin : g_single
        always_ff @(posedge clk) begin
          if (!rstN)                histQ <= '0;
          else if (strobes.shiftEn) histQ <= strobes.shiftBit;
        end
      end

      // R5
      hist_newest_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobes.shiftEn |=> (histQ[0] == $past(strobes.shiftBit)));

      // R9
      hist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !strobes.shiftEn |=> $stable(histQ));
    end else begin : g_nohist
      assign lookIdx = lookRow;
      assign updIdx  = updRow;
      assign histQ   = '0;
    end
  endgenerate

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cell
      assign cellEn[i] = strobes.trainEn && (updIdx == IDX_BITS'(i));

      bp_counter_cell #(
        .CTR_BITS  (CTR_BITS),
        .RESET_VAL (CTR_INIT)
      ) u_cell (
        .clk     (clk),
        .rstN    (rstN),
        .en      (cellEn[i]),
        .countUp (strobes.countUp),
        .value   (ctrVal[i])
      );
    end
  endgenerate

  assign predTaken = ctrVal[lookIdx][CTR_BITS-1];
  assign predHist  = histQ;

  // R6
  one_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cellEn));

  // R6
  train_hits_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.trainEn |-> ($countones(cellEn) == 1));

endmodule

// File: rtl/bp_correlating_predictor.sv
module bp_correlating_predictor
  import bp_pkg::*;
#(
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2,
  parameter int ROW_BITS  = 4,
  parameter int PC_WIDTH  = 32,
  parameter int PC_LSB    = 2,
  localparam int HIST_W   = (HIST_BITS > 0) ? HIST_BITS : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PC_WIDTH-1:0] lookPc,
  output logic                predTaken,
  output logic [HIST_W-1:0]   predHist,
  input  logic                updValid,
  input  logic [PC_WIDTH-1:0] updPc,
  input  logic [HIST_W-1:0]   updHist,
  input  logic                updTaken
);

  bpStrobes_t strobes;

  bp_ctrl #(
    .HIST_BITS (HIST_BITS)
  ) u_ctrl (
    .updValid (updValid),
    .updTaken (updTaken),
    .strobes  (strobes)
  );

  bp_datapath #(
    .HIST_BITS (HIST_BITS),
    .CTR_BITS  (CTR_BITS),
    .ROW_BITS  (ROW_BITS),
    .PC_WIDTH  (PC_WIDTH),
    .PC_LSB    (PC_LSB),
    .HIST_W    (HIST_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .lookPc    (lookPc),
    .updPc     (updPc),
    .updHist   (updHist),
    .predTaken (predTaken),
    .predHist  (predHist)
  );

  // R9
  train_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |-> (!strobes.trainEn && !strobes.shiftEn));

endmodule

// File: tb/sim_bp_correlating_predictor.sv
`timescale 1ns/1ps
module sim_bp_correlating_predictor;

  localparam int ROWS   = 16;
  localparam int COLS   = 4;
  localparam int CMAX   = 3;
  localparam int PERIOD = 20;

  logic        clk = 0;
  logic        rstN = 0;
  logic [31:0] lookPc = '0;
  logic        predTaken;
  logic [1:0]  predHist;
  logic        updValid = 0;
  logic [31:0] updPc = '0;
  logic [1:0]  updHist = '0;
  logic        updTaken = 0;

  int errors = 0;
  int checks = 0;
  int model [ROWS][COLS];
  int mHist = 0;
  logic gotPred;
  logic [1:0] gotHist;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  bp_correlating_predictor u0 (
    .clk (clk), .rstN (rstN), .lookPc (lookPc), .predTaken (predTaken),
    .predHist (predHist), .updValid (updValid), .updPc (updPc),
    .updHist (updHist), .updTaken (updTaken)
  );

  function automatic int rowOf(logic [31:0] pc);
    return int'(pc[5:2]);
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, compare with the model, then advance the model
  task automatic cyc(logic [31:0] lpc, logic uv, logic [31:0] upc, int uh, logic ut);
    @(negedge clk);
    lookPc = lpc; updValid = uv; updPc = upc; updHist = 2'(uh); updTaken = ut;
    #1;
    gotPred = predTaken;
    gotHist = predHist;
    check("R2 pred", int'(gotPred), int'(model[rowOf(lpc)][mHist] >= 2));
    check("R5 hist", int'(gotHist), mHist);
    if (uv) begin
      if (ut) begin
        if (model[rowOf(upc)][uh] < CMAX) model[rowOf(upc)][uh]++;
      end else begin
        if (model[rowOf(upc)][uh] > 0) model[rowOf(upc)][uh]--;
      end
      mHist = ((mHist << 1) | int'(ut)) & (COLS - 1);
    end
  endtask

  task automatic peek(logic [31:0] lpc);
    cyc(lpc, 0, 32'h0, 0, 0);
  endtask

  task automatic upd(logic [31:0] pc, int h, logic t);
    cyc(32'h0, 1, pc, h, t);
  endtask

  // Two not-taken updates to row 2, column 3 bring the history back to zero
  task automatic settle();
    upd(32'h48, 3, 0);
    upd(32'h48, 3, 0);
  endtask

  initial begin
    repeat (PERIOD * 200000) #1;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) model[r][c] = 1;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: weak not-taken everywhere, empty history
    peek(32'h40);
    check("R1 pred", int'(gotPred), 0);
    check("R1 hist", int'(gotHist), 0);
    peek(32'h7C);
    check("R1 pred row15", int'(gotPred), 0);

    // R3: five taken outcomes on row 1, column 0
    repeat (5) upd(32'h44, 0, 1);
    peek(32'h44);
    check("R6 column3 untouched", int'(gotPred), 0);
    check("R5 history 3", int'(gotHist), 3);
    settle();
    peek(32'h44);
    check("R3 trained taken", int'(gotPred), 1);
    // R7: aliasing through high bits, other row unaffected
    peek(32'h1044);
    check("R7 alias same row", int'(gotPred), 1);
    peek(32'hFFFF_FFC0);
    check("R7 row0 untouched", int'(gotPred), 0);

    // R3: saturated at 3, so one decrement still predicts taken
    upd(32'h44, 0, 0);
    peek(32'h44);
    check("R3 ceiling", int'(gotPred), 1);
    upd(32'h44, 0, 0);
    peek(32'h44);
    check("R3 ceiling second step", int'(gotPred), 0);

    // R4: drive to the floor, then one increment must stay not-taken
    repeat (4) upd(32'h44, 0, 0);
    // R8: lookup and update on the same counter in one cycle
    cyc(32'h44, 1, 32'h44, 0, 1);
    check("R8 pre-update pred", int'(gotPred), 0);
    check("R8 pre-update hist", int'(gotHist), 0);
    settle();
    peek(32'h44);
    check("R4 floor", int'(gotPred), 0);
    upd(32'h44, 0, 1);
    settle();
    peek(32'h44);
    check("R3 step to taken", int'(gotPred), 1);

    // R5: taken then not-taken gives history 2'b10
    upd(32'h48, 3, 1);
    upd(32'h48, 3, 0);
    peek(32'h44);
    check("R5 order", int'(gotHist), 2);
    check("R6 column2 untouched", int'(gotPred), 0);

    // R9: update inputs toggling with updValid low
    for (int k = 0; k < 3; k++) cyc(32'h44, 0, 32'h44, 2, 1);
    peek(32'h44);
    check("R9 hist held", int'(gotHist), 2);
    check("R9 counter held", int'(gotPred), 0);

    // R2: random traffic compared with the model every cycle
    for (int k = 0; k < 600; k++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = ($urandom % 3 == 0) ? a : 32'($urandom);
      cyc(a, 1'($urandom), b, int'($urandom % COLS), 1'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule